// File: doc/BRIEF.md
# Block Transfer Host Register Port

This block is the host-facing, byte-wide register window of a block-transfer style management channel. Three offsets are decoded from the low two address bits: a control/status register holding the handshake flags, a data port that feeds a request buffer on writes and drains a response buffer on reads, and an interrupt mask register. A level interrupt line follows the pending flag in the mask register.

The host fills the request buffer byte by byte and then raises host-to-controller attention. The port flags itself busy and gives the message engine a one-cycle request pulse along with the captured byte count. The engine reads the request bytes through a side port. It writes the answer into the response buffer, then signals completion with the answer length. That sets controller-to-host attention and may raise the interrupt. A separate attention input lets the engine flag that an unsolicited message is waiting.

A synchronous active-low reset is the cold reset: it clears every flag, both buffer counts and the interrupt.

Top module: `bt_host_port`

## Requirements
- R1: `host_addr` selects the register: 0 is control, 1 is the data port, 2 is the interrupt mask. A read of offset 3 returns 0xFF. Reads of control and mask have no side effects.
- R2: A control read returns bit7 = controller busy, bit6 = host busy, bit4 = unsolicited attention and bit3 = controller-to-host attention. Bits 5, 2, 1 and 0 read 0. All flags are 0 after reset.
- R3: In a control write, a 1 in bit3 clears controller-to-host attention and a 1 in bit4 clears unsolicited attention. A 1 in bit6 toggles host busy. Zeros in any bit leave that flag unchanged.
- R4: A control write with bit2 set sets controller busy. It also asserts `req_ready` for exactly the one cycle after the write.
- R5: A data write stores the byte at index `req_len` only while `req_len` is below the buffer depth. It increments `req_len` on every write and holds at its all-ones value. A control write with bit0 set zeroes `req_len`. `req_byte` shows the stored byte at `req_idx`.
- R6: A data read with `rsp_len` bytes pending returns the byte at the read pointer and advances the pointer. The read that takes the last byte returns the pointer and the pending count to zero. With nothing pending, a data read returns 0xFF. A control write with bit1 set returns the read pointer to 0.
- R7: A `rsp_done` pulse loads the pending count from `rsp_len`, clears controller busy and sets controller-to-host attention. If the interrupt enable is set and nothing is pending, it also makes the interrupt pending.
- R8: Mask bit0 is the enable and bit1 is pending. Writing the enable from 0 to 1 while either attention flag is set makes the interrupt pending at once. Writing it from 1 to 0 clears the pending flag.
- R9: A mask write with bit1 set clears a pending interrupt.
- R10: A rising `sms_atn_in` sets unsolicited attention if it was clear. It then raises the interrupt when the enable is set and controller-to-host attention is clear. A falling `sms_atn_in` clears the flag if it was set. It then clears a pending interrupt only when controller-to-host attention is clear.
- R11: `irq` equals mask bit1 and stays high until cleared. Reset clears both the enable and the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the addressed register |
| irq | output | 1 | Level interrupt to the host |
| req_ready | output | 1 | One-cycle request pulse to the engine |
| req_len | output | CNT_W | Request bytes written since the last clear |
| req_idx | input | IDX_W | Engine read index into the request buffer |
| req_byte | output | 8 | Request byte at `req_idx` |
| rsp_we | input | 1 | Engine write strobe into the response buffer |
| rsp_idx | input | IDX_W | Engine write index into the response buffer |
| rsp_byte | input | 8 | Engine response byte |
| rsp_done | input | 1 | Response complete pulse |
| rsp_len | input | CNT_W | Response length, at most the buffer depth |
| sms_atn_in | input | 1 | Unsolicited-message attention level |

## Verification
The bench builds the port with an 8-byte buffer and a 5-bit byte counter. A short run then reaches the store cutoff at the end of the request buffer, and a 33-byte burst drives the counter into its hold at 31. A 64-byte buffer would need hundreds of writes for the same two limits. The small response buffer also lets a full drain, a pointer rewind and the empty 0xFF reply be followed byte by byte. The interrupt paths are covered from every source in turn: the enable edge, completion, the attention input with and without the competing flag, and a reset while the interrupt is pending.

// File: rtl/bt_host_pkg.sv
// Shared offsets, bit positions and constants of the block-transfer host port.
package bt_host_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_MASK = 2'd2,
        REG_NONE = 2'd3
    } bt_reg_e;

    // Control register bit positions (host software decodes these)
    localparam int CB_CLR_WR = 0;
    localparam int CB_CLR_RD = 1;
    localparam int CB_H2B    = 2;
    localparam int CB_B2H    = 3;
    localparam int CB_SMS    = 4;
    localparam int CB_HBUSY  = 6;
    localparam int CB_BBUSY  = 7;

    // Mask register bit positions
    localparam int MB_EN   = 0;
    localparam int MB_PEND = 1;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/bt_req_buffer.sv
// Request buffer: the host appends bytes, and the engine reads them by index.
// Assumes: the count may run past DEPTH (overrun detection) and holds at all-ones.
module bt_req_buffer #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    input  logic             clr,
    output logic [CNT_W-1:0] len,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [7:0] mem [DEPTH];
    logic       in_range;

    assign in_range = (len < DEPTH_C);
    assign rd_byte  = mem[rd_idx];

    // Store the byte only while it fits in the buffer
    always_ff @(posedge clk) begin
        if (wr_en && in_range) begin
            mem[len[IDX_W-1:0]] <= wr_byte;
        end
    end

    // Byte count: cleared by the host, counts every write, holds at all-ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len <= '0;
        end else if (clr) begin
            len <= '0;
        end else if (wr_en && len != CNT_MAX) begin
            len <= len + 1'b1;
        end
    end
endmodule

// File: rtl/bt_rsp_buffer.sv
// Response buffer: the engine fills it by index, and the host drains it in order.
// Assumes: load_len never exceeds DEPTH. Draining the last byte empties the buffer.
module bt_rsp_buffer #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [7:0]       eng_byte,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             host_rd,
    input  logic             clr_ptr,
    output logic [7:0]       rd_byte
);
    import bt_host_pkg::*;

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] ptr;
    logic [CNT_W-1:0] cnt;
    logic             pending;

    assign pending = (ptr < cnt);
    assign rd_byte = pending ? mem[ptr[IDX_W-1:0]] : IDLE_BYTE;

    // Engine-side byte writes
    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem[eng_idx] <= eng_byte;
        end
    end

    // Read pointer and pending count; later assignments take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            cnt <= '0;
        end else begin
            if (host_rd && pending) begin
                if (ptr + 1'b1 == cnt) begin
                    ptr <= '0;
                    cnt <= '0;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
            if (clr_ptr) begin
                ptr <= '0;
            end
            if (load) begin
                cnt <= load_len;
            end
        end
    end
endmodule

// File: rtl/bt_flag_ctrl.sv
// Handshake flags and interrupt mask: combines host writes, engine events and
// the attention input into one next-state per cycle.
// Assumes: within a cycle, the host write applies first, then completion, then the attention edge.
module bt_flag_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       mask_we,
    input  logic [7:0] wdata,
    input  logic       rsp_done,
    input  logic       sms_in,
    output logic [7:0] ctrl_q,
    output logic [7:0] mask_q,
    output logic       req_pulse,
    output logic       irq
);
    import bt_host_pkg::*;

    logic b2h, sms, hbusy, bbusy, en, pend, sms_q;
    logic n_b2h, n_sms, n_hbusy, n_bbusy, n_en, n_pend;
    logic sms_rise, sms_fall;

    assign sms_rise = sms_in && !sms_q;
    assign sms_fall = !sms_in && sms_q;

    // Next-state of every flag from this cycle's events
    always_comb begin
        n_b2h   = b2h;
        n_sms   = sms;
        n_hbusy = hbusy;
        n_bbusy = bbusy;
        n_en    = en;
        n_pend  = pend;
        if (ctrl_we) begin
            if (wdata[CB_B2H])   n_b2h   = 1'b0;
            if (wdata[CB_SMS])   n_sms   = 1'b0;
            if (wdata[CB_HBUSY]) n_hbusy = !hbusy;
            if (wdata[CB_H2B])   n_bbusy = 1'b1;
        end
        if (mask_we) begin
            if (wdata[MB_EN] != en) begin
                if (wdata[MB_EN]) begin
                    if (b2h || sms) n_pend = 1'b1;
                    n_en = 1'b1;
                end else begin
                    n_pend = 1'b0;
                    n_en   = 1'b0;
                end
            end
            if (wdata[MB_PEND] && n_pend) n_pend = 1'b0;
        end
        if (rsp_done) begin
            n_bbusy = 1'b0;
            n_b2h   = 1'b1;
            if (n_en && !n_pend) n_pend = 1'b1;
        end
        if (sms_rise && !n_sms) begin
            n_sms = 1'b1;
            if (!n_b2h && n_en) n_pend = 1'b1;
        end else if (sms_fall && n_sms) begin
            n_sms = 1'b0;
            if (!n_b2h && n_pend) n_pend = 1'b0;
        end
    end

    // Flag registers, edge detector and request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b2h       <= 1'b0;
            sms       <= 1'b0;
            hbusy     <= 1'b0;
            bbusy     <= 1'b0;
            en        <= 1'b0;
            pend      <= 1'b0;
            sms_q     <= 1'b0;
            req_pulse <= 1'b0;
        end else begin
            b2h       <= n_b2h;
            sms       <= n_sms;
            hbusy     <= n_hbusy;
            bbusy     <= n_bbusy;
            en        <= n_en;
            pend      <= n_pend;
            sms_q     <= sms_in;
            req_pulse <= ctrl_we && wdata[CB_H2B];
        end
    end

    assign ctrl_q = {bbusy, hbusy, 1'b0, sms, b2h, 3'b000};
    assign mask_q = {6'b0, pend, en};
    assign irq    = pend;
endmodule

// File: rtl/bt_host_port.sv
// Top of the block-transfer host port: decodes offsets, routes the data port
// to the two buffers and muxes read data.
// Assumes: single-byte accesses, with at most one of host_wr and host_rd per cycle.
module bt_host_port #(
    parameter int BUF_DEPTH = 64,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             irq,
    output logic             req_ready,
    output logic [CNT_W-1:0] req_len,
    input  logic [IDX_W-1:0] req_idx,
    output logic [7:0]       req_byte,
    input  logic             rsp_we,
    input  logic [IDX_W-1:0] rsp_idx,
    input  logic [7:0]       rsp_byte,
    input  logic             rsp_done,
    input  logic [CNT_W-1:0] rsp_len,
    input  logic             sms_atn_in
);
    import bt_host_pkg::*;

    bt_reg_e    sel;
    logic       ctrl_we, mask_we, data_we, data_re;
    logic [7:0] ctrl_q, mask_q, rsp_rd_byte;

    assign sel     = bt_reg_e'(host_addr);
    assign ctrl_we = host_wr && sel == REG_CTRL;
    assign mask_we = host_wr && sel == REG_MASK;
    assign data_we = host_wr && sel == REG_DATA;
    assign data_re = host_rd && sel == REG_DATA;

    bt_req_buffer #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_we),
        .wr_byte (host_wdata),
        .clr     (ctrl_we && host_wdata[CB_CLR_WR]),
        .len     (req_len),
        .rd_idx  (req_idx),
        .rd_byte (req_byte)
    );

    bt_rsp_buffer #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .eng_we   (rsp_we),
        .eng_idx  (rsp_idx),
        .eng_byte (rsp_byte),
        .load     (rsp_done),
        .load_len (rsp_len),
        .host_rd  (data_re),
        .clr_ptr  (ctrl_we && host_wdata[CB_CLR_RD]),
        .rd_byte  (rsp_rd_byte)
    );

    bt_flag_ctrl u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .mask_we   (mask_we),
        .wdata     (host_wdata),
        .rsp_done  (rsp_done),
        .sms_in    (sms_atn_in),
        .ctrl_q    (ctrl_q),
        .mask_q    (mask_q),
        .req_pulse (req_ready),
        .irq       (irq)
    );

    // Read-data mux for the addressed register
    always_comb begin
        unique case (sel)
            REG_CTRL: host_rdata = ctrl_q;
            REG_DATA: host_rdata = rsp_rd_byte;
            REG_MASK: host_rdata = mask_q;
            default:  host_rdata = IDLE_BYTE;
        endcase
    end
endmodule

// File: rtl/bt_host_port_chk.sv
// Checker for bt_host_port: temporal relations between host strobes, engine
// events and the outputs. Attached to every instance with bind.
module bt_host_port_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       host_addr,
    input logic             host_wr,
    input logic [7:0]       host_wdata,
    input logic             irq,
    input logic             req_ready,
    input logic [CNT_W-1:0] req_len,
    input logic             rsp_done,
    input logic             sms_atn_in
);
    // R4: a request pulse is always caused by an attention write one cycle earlier
    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> $past(host_wr && host_addr == 2'd0 && host_wdata[2]));

    // R4: the pulse lasts one cycle unless the host asks again
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !(host_wr && host_addr == 2'd0 && host_wdata[2])) |=> !req_ready);

    // R5: the request count only goes down on a clear-write-pointer write
    a_r5_len_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && req_len < $past(req_len))
            |-> $past(host_wr && host_addr == 2'd0 && host_wdata[0]));

    // R11: the interrupt rises only after a mask write, completion or attention input
    a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(irq))
            |-> $past((host_wr && host_addr == 2'd2) || rsp_done || sms_atn_in));

    // R9: outside reset, the interrupt falls only after a mask write or a low attention input
    a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(irq))
            |-> $past((host_wr && host_addr == 2'd2) || !sms_atn_in));
endmodule

bind bt_host_port bt_host_port_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/bt_host_port_test.sv
`timescale 1ns/1ps
module bt_host_port_test;
    localparam int DEPTH = 8;
    localparam int CW    = 5;
    localparam int IW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    host_addr = '0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          irq, req_ready;
    logic [CW-1:0] req_len;
    logic [IW-1:0] req_idx = '0;
    logic [7:0]    req_byte;
    logic          rsp_we = 1'b0;
    logic [IW-1:0] rsp_idx = '0;
    logic [7:0]    rsp_byte = '0;
    logic          rsp_done = 1'b0;
    logic [CW-1:0] rsp_len = '0;
    logic          sms_atn_in = 1'b0;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    bt_host_port #(.BUF_DEPTH(DEPTH), .CNT_W(CW)) uut (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    // Driver: queue the expected byte, the monitor compares it mid-cycle
    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        @(posedge clk); #1;
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic eng_put(int i, logic [7:0] v);
        @(posedge clk); #1;
        rsp_we = 1'b1; rsp_idx = IW'(i); rsp_byte = v;
        @(posedge clk); #1;
        rsp_we = 1'b0;
    endtask

    task automatic eng_done(int n);
        @(posedge clk); #1;
        rsp_done = 1'b1; rsp_len = CW'(n);
        @(posedge clk); #1;
        rsp_done = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: pop and compare each read away from the clock edge
    always @(negedge clk) begin
        if (host_rd) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual=%0h expected=none", host_rdata);
            end else begin
                chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // Reset state and decode
        chk("R11 irq after reset", irq, 0);
        rd(2'd0, 8'h00, "R2 ctrl reset");
        rd(2'd2, 8'h00, "R11 mask reset");
        rd(2'd1, 8'hFF, "R6 empty data read");
        rd(2'd3, 8'hFF, "R1 offset3");

        // Request capture and handshake
        for (int i = 0; i < 5; i++) wr(2'd1, 8'h10 + 8'(i));
        chk("R5 req_len five", req_len, 5);
        req_idx = 3'd2; #1;
        chk("R5 req_byte idx2", req_byte, 8'h12);
        wr(2'd0, 8'h04);
        chk("R4 req_ready pulse", req_ready, 1);
        idle(1);
        chk("R4 req_ready single", req_ready, 0);
        rd(2'd0, 8'h80, "R4 bmc busy set");
        rd(2'd0, 8'h80, "R1 ctrl read no side effect");
        wr(2'd0, 8'h40);
        rd(2'd0, 8'hC0, "R3 host busy toggled on");
        wr(2'd0, 8'h40);
        rd(2'd0, 8'h80, "R3 host busy toggled off");
        wr(2'd0, 8'h01);
        chk("R5 clear write count", req_len, 0);

        // Overrun: count runs past the depth, storing stops at the end
        for (int i = 0; i < 10; i++) wr(2'd1, 8'h20 + 8'(i));
        chk("R5 overrun count", req_len, 10);
        req_idx = 3'd7; #1;
        chk("R5 last stored byte", req_byte, 8'h27);
        req_idx = 3'd0; #1;
        chk("R5 first byte kept", req_byte, 8'h20);
        for (int i = 0; i < 23; i++) wr(2'd1, 8'h55);
        chk("R5 count holds at max", req_len, 31);
        wr(2'd0, 8'h01);

        // Response delivery, drain and rewind (interrupt disabled)
        eng_put(0, 8'hA0); eng_put(1, 8'hA1); eng_put(2, 8'hA2);
        eng_done(3);
        chk("R7 no irq while disabled", irq, 0);
        rd(2'd0, 8'h08, "R7 b2h set busy cleared");
        rd(2'd1, 8'hA0, "R6 byte0");
        rd(2'd1, 8'hA1, "R6 byte1");
        wr(2'd0, 8'h02);
        rd(2'd1, 8'hA0, "R6 rewind byte0");
        rd(2'd1, 8'hA1, "R6 rewind byte1");
        rd(2'd1, 8'hA2, "R6 rewind byte2");
        rd(2'd1, 8'hFF, "R6 drained");

        // Enable with attention pending
        wr(2'd2, 8'h01);
        chk("R8 enable raises irq", irq, 1);
        rd(2'd2, 8'h03, "R11 mask shows pending");
        rd(2'd2, 8'h03, "R1 mask read no side effect");
        wr(2'd2, 8'h03);
        chk("R9 clear pending", irq, 0);
        wr(2'd0, 8'h08);
        rd(2'd0, 8'h00, "R3 b2h cleared by write");
        eng_done(1);
        chk("R7 completion raises irq", irq, 1);
        rd(2'd0, 8'h08, "R7 b2h after completion");
        wr(2'd2, 8'h00);
        chk("R8 disable clears irq", irq, 0);
        rd(2'd2, 8'h00, "R8 mask after disable");
        rd(2'd1, 8'hA0, "R6 reload one byte");
        rd(2'd1, 8'hFF, "R6 one byte drained");

        // Attention input
        wr(2'd0, 8'h08);
        wr(2'd2, 8'h01);
        chk("R8 enable without attention", irq, 0);
        sms_atn_in = 1'b1; idle(2);
        chk("R10 rise raises irq", irq, 1);
        rd(2'd0, 8'h10, "R10 sms flag set");
        sms_atn_in = 1'b0; idle(2);
        chk("R10 fall clears irq", irq, 0);
        rd(2'd0, 8'h00, "R10 sms flag cleared");
        eng_done(0);
        wr(2'd2, 8'h03);
        chk("R9 clear before sms test", irq, 0);
        sms_atn_in = 1'b1; idle(2);
        chk("R10 rise masked by b2h", irq, 0);
        rd(2'd0, 8'h18, "R10 both attentions");
        wr(2'd0, 8'h10);
        rd(2'd0, 8'h08, "R3 sms cleared by write");
        sms_atn_in = 1'b0; idle(2);
        rd(2'd0, 8'h08, "R10 fall with flag clear");

        // Reset while pending
        wr(2'd0, 8'h08);
        eng_done(0);
        chk("R7 irq before reset", irq, 1);
        rst_n = 1'b0; idle(2);
        rst_n = 1'b1; idle(1);
        chk("R11 reset clears irq", irq, 0);
        rd(2'd2, 8'h00, "R11 reset clears mask");
        rd(2'd0, 8'h00, "R2 reset clears ctrl");

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule